// File: doc/BRIEF.md
# Learning Layer-2 Forwarding Engine

This block moves Ethernet frames between a set of ports. Each ingress port delivers a byte stream of 9-bit words in which bit 8 flags the opening byte of a frame. The engine visits the ingress ports one after another and takes the next frame it finds. It collects the two MAC addresses at the head of the frame and records which port the source address sits behind. It then sends the frame to one or more egress ports.

Address learning uses a small associative table. Each entry holds a 48-bit key, a valid flag and a port number, and the table supports match, insert and delete. A destination found in the table sends the frame to the single recorded port. An unknown destination sends it to every port except the one it arrived on. When a known source turns up on a different port, its entry is removed and written again with the new port.

Each egress port is a write port with a ready input, as for a FIFO write side. All egress ports share the data value, and each has its own write strobe. The block is meant to sit between per-port receive and transmit FIFOs inside a larger switch fabric.

Top module: `l2_fwd_engine`

## Requirements
- R1: A rising clock edge with rst_n low empties the table and sets the scan position to ingress port 0. In the first cycle after reset, all out_wr bits are low and in_ready is high only for port 0.
- R2: While idle, the block reads one word per cycle from the current scan port. If that port has no word, or the word has bit 8 clear, the block discards the word and moves the scan to the next port number, wrapping after the last. A discarded word never appears on any egress port.
- R3: A frame begins with a word whose bit 8 is set. That byte and the next five bytes form the destination MAC, most significant byte first. The six bytes after those form the source MAC in the same byte order.
- R4: If the source MAC of a frame is not in the table, it is inserted mapped to the ingress port. Later frames addressed to that MAC leave only through that port.
- R5: If the source MAC is in the table with a different port, the old entry is deleted and the MAC is inserted again with the new ingress port. Later frames addressed to it leave only through the new port.
- R6: A frame whose destination MAC is not in the table is written to every egress port except its ingress port.
- R7: A frame whose destination MAC is in the table is written only to the mapped egress port.
- R8: On each selected egress port the bytes appear in this order: the six destination bytes, the six source bytes, then the payload bytes as received. Bit 8 is set on the first of these bytes and clear on all others.
- R9: A frame ends at the first cycle in which its ingress port has no valid word. Scanning then resumes at the next port number.
- R10: During forwarding, a word with bit 8 set ends the current frame and is not consumed. It becomes destination byte 0 of the next frame taken from that same port.
- R11: While any selected egress port has out_ready low, no out_wr bit is raised and no payload word is taken from the ingress port. Once every selected port is ready, the frame continues with no byte lost or repeated.
- R12: The table holds TABLE_DEPTH entries, and each insert uses the lowest free entry. An insert into a full table is dropped: that MAC stays unknown and the existing entries still forward as before.
- R13: Each table lookup is answered on the following cycle by exactly one single-cycle pulse, either hit (with the entry index and port) or miss. No pulse occurs without a lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_data | input | NUM_PORTS*9 | Ingress words; port p uses bits [p*9+8:p*9], and bit 8 marks a frame's first byte |
| in_valid | input | NUM_PORTS | Ingress word present, one bit per port |
| in_ready | output | NUM_PORTS | Ingress word consumed at this edge, one bit per port |
| out_data | output | NUM_PORTS*9 | Egress words, laid out like in_data; the same value goes to every port |
| out_wr | output | NUM_PORTS | Egress write strobe, one bit per port |
| out_ready | input | NUM_PORTS | Egress port can accept a write |

## Verification
The first patterns send a frame to an unknown destination and then a frame to a learned one. Together they separate flooding from single-port delivery and show whether the source was recorded against the right port. A stream with stray non-start words ahead of a frame tests whether the idle scan discards and rotates. The same source appearing on a new port, and a source arriving once the table is full, tell a replaced mapping apart from a dropped insert. Back-to-back frames on one port check that a start word ends a frame without being lost. A held-low ready on one flooded port checks that the whole egress stalls and then resumes intact.

// File: rtl/l2fwd_pkg.sv
// Shared constants and types for the forwarding engine.
package l2fwd_pkg;
    localparam int WORD_W    = 9;
    localparam int BYTE_W    = 8;
    localparam int MAC_W     = 48;
    localparam int HDR_BYTES = 12;
    localparam int HDR_W     = HDR_BYTES * BYTE_W;
    localparam int CNT_W     = $clog2(HDR_BYTES + 1);

    typedef logic [MAC_W-1:0] mac_t;

    typedef enum logic [3:0] {
        ST_SCAN,
        ST_HDR_IN,
        ST_SRC_LK,
        ST_SRC_RES,
        ST_DEL,
        ST_INS,
        ST_DST_LK,
        ST_DST_RES,
        ST_HDR_OUT,
        ST_FWD
    } fwd_state_e;
endpackage

// File: rtl/l2fwd_mac_table.sv
// Associative MAC-to-port table.
// Does: lookup compares the key against every valid entry and returns a
// registered hit or miss pulse one cycle later, with the lowest matching
// index and its port. Insert writes the lowest free entry and is dropped
// when the table is full. Delete clears the valid flag of one index.
// Assumes: keys are unique, so at most one entry matches, and insert and
// delete are never requested in the same cycle.
module l2fwd_mac_table
    import l2fwd_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int PORT_W = 2,
    parameter int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_req,
    input  mac_t              lk_key,
    output logic              lk_hit,
    output logic              lk_miss,
    output logic [IDX_W-1:0]  lk_idx,
    output logic [PORT_W-1:0] lk_port,
    input  logic              ins_req,
    input  mac_t              ins_key,
    input  logic [PORT_W-1:0] ins_port,
    input  logic              del_req,
    input  logic [IDX_W-1:0]  del_idx
);
    logic [DEPTH-1:0]  vld;
    logic [DEPTH-1:0]  hit_vec;
    mac_t              key_mem  [DEPTH];
    logic [PORT_W-1:0] port_mem [DEPTH];
    logic [IDX_W-1:0]  hit_idx;
    logic [IDX_W-1:0]  free_idx;
    logic              any_hit;
    logic              any_free;

    // One comparator per entry.
    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_cmp
            assign hit_vec[g] = vld[g] && (key_mem[g] == lk_key);
        end
    endgenerate

    // Priority encoders: lowest matching index and lowest free index.
    always_comb begin
        hit_idx  = '0;
        free_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (hit_vec[i]) hit_idx = IDX_W'(i);
            if (!vld[i])    free_idx = IDX_W'(i);
        end
    end

    assign any_hit  = |hit_vec;
    assign any_free = ~&vld;

    // Registered lookup answer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lk_hit  <= 1'b0;
            lk_miss <= 1'b0;
            lk_idx  <= '0;
            lk_port <= '0;
        end else begin
            lk_hit  <= lk_req && any_hit;
            lk_miss <= lk_req && !any_hit;
            lk_idx  <= hit_idx;
            lk_port <= port_mem[hit_idx];
        end
    end

    // Valid flags: delete clears, insert sets the lowest free entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= '0;
        end else begin
            if (del_req)              vld[del_idx]  <= 1'b0;
            if (ins_req && any_free)  vld[free_idx] <= 1'b1;
        end
    end

    // Key and port storage, written only on an accepted insert.
    always_ff @(posedge clk) begin
        if (ins_req && any_free) begin
            key_mem[free_idx]  <= ins_key;
            port_mem[free_idx] <= ins_port;
        end
    end
endmodule

// File: rtl/l2fwd_ctrl.sv
// Forwarding control FSM.
// Does: scans the ingress ports in turn for a start word and collects the
// 12 header bytes. It learns the source (delete then insert when the port
// has moved) and looks up the destination to pick the egress set. It then
// writes the header and passes the payload through until the ingress
// stream runs dry or a new start word appears.
// Assumes: the table answers a lookup one cycle after the request, and an
// egress write lands when out_wr and out_ready are both high.
module l2fwd_ctrl
    import l2fwd_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int PORT_W    = 2,
    parameter int IDX_W     = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [WORD_W-1:0]    in_word [NUM_PORTS],
    input  logic [NUM_PORTS-1:0] in_valid,
    output logic [NUM_PORTS-1:0] in_ready,
    output logic [WORD_W-1:0]    eg_word,
    output logic [NUM_PORTS-1:0] eg_wr,
    input  logic [NUM_PORTS-1:0] eg_ready,
    output logic                 lk_req,
    output mac_t                 lk_key,
    input  logic                 lk_hit,
    input  logic                 lk_miss,
    input  logic [IDX_W-1:0]     lk_idx,
    input  logic [PORT_W-1:0]    lk_port,
    output logic                 ins_req,
    output mac_t                 ins_key,
    output logic [PORT_W-1:0]    ins_port,
    output logic                 del_req,
    output logic [IDX_W-1:0]     del_idx
);
    fwd_state_e            state;
    logic [PORT_W-1:0]     rr;
    logic [PORT_W-1:0]     cur;
    logic [PORT_W-1:0]     view;
    logic [HDR_W-1:0]      hdr;
    logic [CNT_W-1:0]      cnt;
    logic [NUM_PORTS-1:0]  sel;
    logic [IDX_W-1:0]      old_idx;
    logic [WORD_W-1:0]     vw;
    logic                  vv;
    logic                  eg_ok;
    logic                  last_hdr;

    function automatic logic [PORT_W-1:0] next_port(input logic [PORT_W-1:0] p);
        return (p == PORT_W'(NUM_PORTS - 1)) ? '0 : p + 1'b1;
    endfunction

    // Ingress word currently in view: the scan port while idle, else the frame's port.
    assign view     = (state == ST_SCAN) ? rr : cur;
    assign vw       = in_word[view];
    assign vv       = in_valid[view];
    assign eg_ok    = &(eg_ready | ~sel);
    assign last_hdr = (cnt == CNT_W'(HDR_BYTES - 1));

    // Table requests.
    assign lk_req   = (state == ST_SRC_LK) || (state == ST_DST_LK);
    assign lk_key   = (state == ST_SRC_LK) ? hdr[MAC_W-1:0] : hdr[HDR_W-1 -: MAC_W];
    assign ins_req  = (state == ST_INS);
    assign ins_key  = hdr[MAC_W-1:0];
    assign ins_port = cur;
    assign del_req  = (state == ST_DEL);
    assign del_idx  = old_idx;

    // Handshakes and egress data for the current state.
    always_comb begin
        in_ready = '0;
        eg_wr    = '0;
        eg_word  = '0;
        case (state)
            ST_SCAN:   in_ready[rr]  = 1'b1;
            ST_HDR_IN: in_ready[cur] = 1'b1;
            ST_HDR_OUT: begin
                eg_word = {(cnt == '0), hdr[HDR_W-1 -: BYTE_W]};
                if (eg_ok) eg_wr = sel;
            end
            ST_FWD: begin
                eg_word = {1'b0, vw[BYTE_W-1:0]};
                if (vv && !vw[WORD_W-1] && eg_ok) begin
                    in_ready[cur] = 1'b1;
                    eg_wr         = sel;
                end
            end
            default: ;
        endcase
    end

    // State, scan position, header buffer and egress selection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_SCAN;
            rr      <= '0;
            cur     <= '0;
            hdr     <= '0;
            cnt     <= '0;
            sel     <= '0;
            old_idx <= '0;
        end else begin
            case (state)
                ST_SCAN: begin
                    if (vv && vw[WORD_W-1]) begin
                        hdr   <= {hdr[HDR_W-BYTE_W-1:0], vw[BYTE_W-1:0]};
                        cur   <= rr;
                        cnt   <= CNT_W'(1);
                        state <= ST_HDR_IN;
                    end else begin
                        rr <= next_port(rr);
                    end
                end
                ST_HDR_IN: begin
                    if (vv) begin
                        hdr <= {hdr[HDR_W-BYTE_W-1:0], vw[BYTE_W-1:0]};
                        cnt <= cnt + 1'b1;
                        if (last_hdr) state <= ST_SRC_LK;
                    end
                end
                ST_SRC_LK: state <= ST_SRC_RES;
                ST_SRC_RES: begin
                    if (lk_hit) begin
                        if (lk_port == cur) begin
                            state <= ST_DST_LK;
                        end else begin
                            old_idx <= lk_idx;
                            state   <= ST_DEL;
                        end
                    end else if (lk_miss) begin
                        state <= ST_INS;
                    end
                end
                ST_DEL:    state <= ST_INS;
                ST_INS:    state <= ST_DST_LK;
                ST_DST_LK: state <= ST_DST_RES;
                ST_DST_RES: begin
                    sel   <= lk_hit ? (NUM_PORTS'(1) << lk_port) : ~(NUM_PORTS'(1) << cur);
                    cnt   <= '0;
                    state <= ST_HDR_OUT;
                end
                ST_HDR_OUT: begin
                    if (eg_ok) begin
                        hdr <= {hdr[HDR_W-BYTE_W-1:0], {BYTE_W{1'b0}}};
                        cnt <= cnt + 1'b1;
                        if (last_hdr) state <= ST_FWD;
                    end
                end
                ST_FWD: begin
                    if (!vv) begin
                        rr    <= next_port(cur);
                        state <= ST_SCAN;
                    end else if (vw[WORD_W-1]) begin
                        rr    <= cur;
                        state <= ST_SCAN;
                    end
                end
                default: state <= ST_SCAN;
            endcase
        end
    end
endmodule

// File: rtl/l2_fwd_engine.sv
// Learning layer-2 forwarding engine, top level.
// Does: maps the flat per-port buses onto the control FSM and the MAC
// table. The one egress word is copied to every egress lane, and each
// lane has its own write strobe.
// Assumes: NUM_PORTS >= 2, and every ingress port holds its word steady
// until in_ready takes it.
module l2_fwd_engine
    import l2fwd_pkg::*;
#(
    parameter int NUM_PORTS   = 4,
    parameter int TABLE_DEPTH = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_PORTS*WORD_W-1:0] in_data,
    input  logic [NUM_PORTS-1:0]        in_valid,
    output logic [NUM_PORTS-1:0]        in_ready,
    output logic [NUM_PORTS*WORD_W-1:0] out_data,
    output logic [NUM_PORTS-1:0]        out_wr,
    input  logic [NUM_PORTS-1:0]        out_ready
);
    localparam int PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
    localparam int IDX_W  = (TABLE_DEPTH > 1) ? $clog2(TABLE_DEPTH) : 1;

    logic [WORD_W-1:0] in_word [NUM_PORTS];
    logic [WORD_W-1:0] eg_word;
    logic              lk_req;
    mac_t              lk_key;
    logic              lk_hit;
    logic              lk_miss;
    logic [IDX_W-1:0]  lk_idx;
    logic [PORT_W-1:0] lk_port;
    logic              ins_req;
    mac_t              ins_key;
    logic [PORT_W-1:0] ins_port;
    logic              del_req;
    logic [IDX_W-1:0]  del_idx;

    // Per-port slicing of the flat ingress and egress buses.
    genvar g;
    generate
        for (g = 0; g < NUM_PORTS; g++) begin : g_lane
            assign in_word[g]                  = in_data[g*WORD_W +: WORD_W];
            assign out_data[g*WORD_W +: WORD_W] = eg_word;
        end
    endgenerate

    l2fwd_ctrl #(
        .NUM_PORTS (NUM_PORTS),
        .PORT_W    (PORT_W),
        .IDX_W     (IDX_W)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_word  (in_word),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .eg_word  (eg_word),
        .eg_wr    (out_wr),
        .eg_ready (out_ready),
        .lk_req   (lk_req),
        .lk_key   (lk_key),
        .lk_hit   (lk_hit),
        .lk_miss  (lk_miss),
        .lk_idx   (lk_idx),
        .lk_port  (lk_port),
        .ins_req  (ins_req),
        .ins_key  (ins_key),
        .ins_port (ins_port),
        .del_req  (del_req),
        .del_idx  (del_idx)
    );

    l2fwd_mac_table #(
        .DEPTH  (TABLE_DEPTH),
        .PORT_W (PORT_W),
        .IDX_W  (IDX_W)
    ) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_req   (lk_req),
        .lk_key   (lk_key),
        .lk_hit   (lk_hit),
        .lk_miss  (lk_miss),
        .lk_idx   (lk_idx),
        .lk_port  (lk_port),
        .ins_req  (ins_req),
        .ins_key  (ins_key),
        .ins_port (ins_port),
        .del_req  (del_req),
        .del_idx  (del_idx)
    );
endmodule

// File: rtl/l2_fwd_engine_chk.sv
// Protocol checks for the forwarding engine, bound to the top level.
// Does: watches the table lookup handshake, ingress read exclusivity and
// egress write readiness.
// Assumes: synchronous active-low reset shared with the engine.
module l2_fwd_engine_chk #(
    parameter int NUM_PORTS = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_PORTS-1:0] in_ready,
    input logic [NUM_PORTS-1:0] out_wr,
    input logic [NUM_PORTS-1:0] out_ready,
    input logic                 lk_req,
    input logic                 lk_hit,
    input logic                 lk_miss
);
    // R13
    lk_single_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(lk_hit && lk_miss));

    // R13
    lk_answered_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> (lk_hit || lk_miss));

    // R13
    lk_no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> !(lk_hit || lk_miss));

    // R2
    one_ingress_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(in_ready));

    // R11
    wr_when_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_wr & ~out_ready) == '0);
endmodule

bind l2_fwd_engine l2_fwd_engine_chk #(.NUM_PORTS(NUM_PORTS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .out_wr    (out_wr),
    .out_ready (out_ready),
    .lk_req    (lk_req),
    .lk_hit    (lk_hit),
    .lk_miss   (lk_miss)
);

// File: tb/l2_fwd_engine_bench.sv
// Directed bench: ingress queues feed the ports and egress writes are
// captured per port, then each task compares the result with the frames
// it expects.
module l2_fwd_engine_bench;
    localparam int NP    = 4;
    localparam int DEPTH = 4;

    typedef logic [8:0] wq_t [$];

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NP*9-1:0] in_data = '0;
    logic [NP-1:0]   in_valid = '0;
    logic [NP-1:0]   in_ready;
    logic [NP*9-1:0] out_data;
    logic [NP-1:0]   out_wr;
    logic [NP-1:0]   out_ready = '1;
    logic [NP-1:0]   rdy_mask = '1;
    logic [NP-1:0]   pop_pend = '0;

    wq_t inq  [NP];
    wq_t outq [NP];
    wq_t expq [NP];
    int  total = 0;
    int  bad   = 0;

    localparam logic [47:0] MAC_A = 48'h0A1122334401;
    localparam logic [47:0] MAC_B = 48'h0B5566778802;
    localparam logic [47:0] MAC_C = 48'h0C99AABBCC03;
    localparam logic [47:0] MAC_D = 48'h0DDDEEFF0004;
    localparam logic [47:0] MAC_E = 48'h0E1357913505;
    localparam logic [47:0] MAC_X = 48'hF0F1F2F3F4F5;
    localparam logic [47:0] MAC_Y = 48'hE0E1E2E3E4E5;
    localparam logic [47:0] MAC_Z = 48'hD0D1D2D3D4D5;
    localparam logic [47:0] MAC_W = 48'hC0C1C2C3C4C5;

    always #2 clk = ~clk;

    l2_fwd_engine #(.NUM_PORTS(NP), .TABLE_DEPTH(DEPTH)) u_l2_fwd_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_data   (in_data),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .out_data  (out_data),
        .out_wr    (out_wr),
        .out_ready (out_ready)
    );

    // Between edges: retire consumed words, drive queue heads, record handshakes.
    always @(negedge clk) begin
        for (int p = 0; p < NP; p++)
            if (pop_pend[p] && inq[p].size() > 0) void'(inq[p].pop_front());
        for (int p = 0; p < NP; p++) begin
            if (inq[p].size() > 0) begin
                in_valid[p]       = 1'b1;
                in_data[p*9 +: 9] = inq[p][0];
            end else begin
                in_valid[p]       = 1'b0;
                in_data[p*9 +: 9] = '0;
            end
        end
        out_ready = rdy_mask;
        #1;
        for (int p = 0; p < NP; p++) begin
            pop_pend[p] = rst_n && in_valid[p] && in_ready[p];
            if (rst_n && out_wr[p] && out_ready[p]) outq[p].push_back(out_data[p*9 +: 9]);
        end
    end

    function automatic wq_t mk_frame(logic [47:0] d, logic [47:0] s, int n, logic [7:0] seed);
        wq_t f;
        for (int i = 0; i < 6; i++) f.push_back({(i == 0), d[47-8*i -: 8]});
        for (int i = 0; i < 6; i++) f.push_back({1'b0, s[47-8*i -: 8]});
        for (int i = 0; i < n; i++) f.push_back({1'b0, 8'(seed + 8'(i * 7))});
        return f;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send(input int p, input wq_t f);
        inq[p] = {inq[p], f};
    endtask

    task automatic expect_on(input int p, input wq_t f);
        expq[p] = {expq[p], f};
    endtask

    task automatic settle();
        bit busy = 1'b1;
        while (busy) begin
            busy = 1'b0;
            for (int p = 0; p < NP; p++) if (inq[p].size() > 0) busy = 1'b1;
            @(negedge clk);
        end
        repeat (40) @(negedge clk);
    endtask

    // Compare the captured egress of every port with the expected frames, then clear.
    task automatic compare_ports(input string tag);
        for (int p = 0; p < NP; p++) begin
            int mis = -1;
            int a = 0;
            int e = 0;
            if (outq[p].size() != expq[p].size()) begin
                mis = 0;
                a = outq[p].size();
                e = expq[p].size();
            end else begin
                for (int i = 0; i < outq[p].size(); i++)
                    if (mis < 0 && outq[p][i] !== expq[p][i]) begin
                        mis = i;
                        a = int'(outq[p][i]);
                        e = int'(expq[p][i]);
                    end
            end
            check(mis < 0, $sformatf("%s port%0d word%0d", tag, p, mis), a, e);
            outq[p].delete();
            expq[p].delete();
        end
    endtask

    // R1: state right after reset.
    task automatic t_reset();
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(out_wr == '0, "R1 no egress write after reset", int'(out_wr), 0);
        check(in_ready == 4'b0001, "R1 scan starts at port 0", int'(in_ready), 1);
        repeat (4) @(negedge clk);
    endtask

    // R3 R4 R6 R8: unknown destination floods all but ingress.
    task automatic t_flood();
        wq_t f = mk_frame(MAC_X, MAC_A, 5, 8'h10);
        send(0, f);
        for (int p = 1; p < NP; p++) expect_on(p, f);
        settle();
        compare_ports("R6 R8 R3 flood from port0");
    endtask

    // R4 R7 R13: destination learned earlier goes to one port only.
    task automatic t_known();
        wq_t f = mk_frame(MAC_A, MAC_B, 3, 8'h20);
        send(2, f);
        expect_on(0, f);
        settle();
        compare_ports("R4 R7 R13 learned destination");
    endtask

    // R2: stray words ahead of a frame are discarded.
    task automatic t_scan_skip();
        wq_t g = '{9'h0AA, 9'h055, 9'h0C3};
        wq_t f = mk_frame(MAC_B, MAC_C, 4, 8'h30);
        send(1, g);
        send(1, f);
        expect_on(2, f);
        settle();
        compare_ports("R2 stray words discarded");
    endtask

    // R5: a source moving port is remapped.
    task automatic t_relearn();
        wq_t f1 = mk_frame(MAC_Z, MAC_A, 2, 8'h40);
        wq_t f2 = mk_frame(MAC_A, MAC_D, 3, 8'h50);
        send(3, f1);
        expect_on(0, f1);
        expect_on(1, f1);
        expect_on(2, f1);
        settle();
        compare_ports("R5 R6 moved source floods");
        send(1, f2);
        expect_on(3, f2);
        settle();
        compare_ports("R5 remapped destination");
    endtask

    // R12: a full table drops the insert and keeps old entries.
    task automatic t_full();
        wq_t f1 = mk_frame(MAC_Y, MAC_E, 2, 8'h60);
        wq_t f2 = mk_frame(MAC_E, MAC_B, 2, 8'h70);
        wq_t f3 = mk_frame(MAC_C, MAC_A, 2, 8'h80);
        send(0, f1);
        for (int p = 1; p < NP; p++) expect_on(p, f1);
        settle();
        compare_ports("R12 R6 source into full table");
        send(2, f2);
        expect_on(0, f2);
        expect_on(1, f2);
        expect_on(3, f2);
        settle();
        compare_ports("R12 dropped source stays unknown");
        send(3, f3);
        expect_on(1, f3);
        settle();
        compare_ports("R12 R7 old entries kept");
    endtask

    // R9 R10: a start word ends a frame and opens the next.
    task automatic t_back2back();
        wq_t f1 = mk_frame(MAC_C, MAC_B, 4, 8'h90);
        wq_t f2 = mk_frame(MAC_D, MAC_B, 2, 8'hA0);
        send(2, {f1, f2});
        expect_on(1, f1);
        expect_on(1, f2);
        settle();
        compare_ports("R10 R9 back-to-back frames");
    endtask

    // R11: one unready selected port stalls all egress.
    task automatic t_stall();
        wq_t f = mk_frame(MAC_W, MAC_B, 6, 8'hB0);
        rdy_mask = 4'b1101;
        send(2, f);
        repeat (60) @(negedge clk);
        begin
            int n = 0;
            for (int p = 0; p < NP; p++) n += outq[p].size();
            check(n == 0, "R11 no write while a port is unready", n, 0);
        end
        rdy_mask = '1;
        expect_on(0, f);
        expect_on(1, f);
        expect_on(3, f);
        settle();
        compare_ports("R11 frame intact after stall");
    endtask

    initial begin
        t_reset();
        t_flood();
        t_known();
        t_scan_skip();
        t_relearn();
        t_full();
        t_back2back();
        t_stall();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule